// File: doc/BRIEF.md
# Micro-op Dispatch Slot Controller

This block meters how many micro-ops an out-of-order front end may send downstream in each clock cycle. Several instruction descriptors arrive per cycle on parallel lanes, in program order. Each descriptor carries:

- a micro-op count;
- a flag that requires the instruction to open a fresh dispatch group;
- a flag that closes the group once the instruction has gone.

For each lane the block decides whether the instruction may leave in this cycle. It weighs the slots still free against three handshake inputs: retire-unit space, destination-register availability and the next stage's readiness. It holds no instruction storage; a lane is either taken in the same cycle or stays with its producer.

An instruction with more micro-ops than the dispatch width takes the whole cycle. The remainder is kept as a carry-over count and drained in the following cycles before other work may use the slots. Each cycle the block reports the number of micro-ops sent from newly accepted lanes, and separately the number drained from carry-over. A one-cycle-late stall flag reports a lane that had the slots but was refused for lack of retire space or registers.

Top module: `uop_dispatch_ctrl`

## Requirements
- R1: After synchronous active-low reset the carry-over count is zero, no carry event is reported, both stall flags are low, and the first cycle offers the full width.
- R2: A cycle that starts with no carry-over offers the full dispatch width W (parameter, default 4; a width of zero selects the issue-width parameter).
- R3: A lane needs min(micro-op count, W) free slots and is refused when fewer remain after the lanes before it.
- R4: A lane whose count exceeds W is taken only when all W slots are free. It uses them all and leaves count minus W as carry-over.
- R5: A cycle that starts with carry-over C raises the carry event with min(C, W) micro-ops, and it offers W minus C slots, or none when C is at least W.
- R6: While carry-over remaining after this cycle's drain is non-zero (C greater than W), no lane is ready.
- R7: A lane flagged begin-group is ready only when the slots free at that lane equal W.
- R8: A lane flagged end-group leaves zero free slots for the lanes after it.
- R9: A lane is ready only when its retire-space, register-availability and next-stage-ready inputs are all high.
- R10: Lanes are taken in order: lane i is ready only when lane i-1 is valid and taken, so accepted lanes always form a prefix starting at lane 0.
- R11: A valid lane that had its slots, its begin-group condition and no carry blocking, but lacked retire space (or registers), raises stall_rob (or stall_regs) in the next cycle.
- R12: The dispatch report gives the sum of min(count, W) over the lanes taken in this cycle, and disp_valid is high when any lane is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | LANES | Per-lane descriptor valid, lane 0 oldest |
| in_uops | input | LANES*UOP_W | Micro-op counts, lane i at bits [i*UOP_W +: UOP_W] |
| in_bgn | input | LANES | Begin-group flag per lane |
| in_end | input | LANES | End-group flag per lane |
| rob_ok | input | LANES | Retire unit has room for the lane's micro-ops |
| regs_ok | input | LANES | Destination registers available for the lane |
| nxt_rdy | input | LANES | Next stage can take the lane this cycle |
| lane_rdy | output | LANES | Lane may dispatch; taken when valid and ready |
| disp_valid | output | 1 | At least one lane taken this cycle |
| disp_uops | output | SUM_W | Micro-ops sent by lanes taken this cycle |
| carry_valid | output | 1 | Carry-over drained this cycle |
| carry_uops | output | SLOT_W | Micro-ops drained from carry-over this cycle |
| stall_rob | output | 1 | Retire-space shortage seen last cycle |
| stall_regs | output | 1 | Register shortage seen last cycle |

## Verification
A wrong carry-over count appears at the ports in the very next cycle. The carry event then shows the wrong drain amount, and the lanes in that cycle become ready when they should be blocked, or blocked when they should be ready. A corrupted slot budget within the cycle shows at once as a wrong lane_rdy pattern and a dispatch total that disagrees with the accepted lanes. Stall flags lag by exactly one cycle, so a fault in their source shows one edge after the refused lane.

// File: rtl/dsp_pkg.sv
// Package: shared helpers for the dispatch slot controller.
// Assumes widths are small positive integers.
package dsp_pkg;

    // Pick the effective dispatch width, falling back to the issue width on zero.
    function automatic int unsigned eff_width(input int unsigned dw, input int unsigned iw);
        return (dw == 0) ? iw : dw;
    endfunction

endpackage

// File: rtl/dsp_lane.sv
// Module: dsp_lane
// Decides for one lane whether its instruction may dispatch this cycle,
// given the slots left by older lanes. Purely combinational.
// Assumes UOP_W can hold EFF_W.
module dsp_lane #(
    parameter int unsigned EFF_W  = 4,
    parameter int unsigned UOP_W  = 4,
    parameter int unsigned SLOT_W = 3
) (
    input  logic              go_in,
    input  logic              blocked,
    input  logic [SLOT_W-1:0] avail_in,
    input  logic              valid,
    input  logic [UOP_W-1:0]  uops,
    input  logic              bgn,
    input  logic              endg,
    input  logic              rob_ok,
    input  logic              regs_ok,
    input  logic              nxt_rdy,
    output logic              ready,
    output logic              accept,
    output logic [SLOT_W-1:0] avail_out,
    output logic [SLOT_W-1:0] slots_used,
    output logic [UOP_W-1:0]  excess,
    output logic              short_rob,
    output logic              short_regs
);
    localparam logic [UOP_W-1:0]  W_U = UOP_W'(EFF_W);
    localparam logic [SLOT_W-1:0] W_S = SLOT_W'(EFF_W);

    logic              wide;
    logic [SLOT_W-1:0] req;
    logic              slots_fit;
    logic              group_ok;
    logic              considered;

    // Slots this instruction needs: its count, capped at the width.
    always_comb begin
        wide = (uops > W_U);
        req  = wide ? W_S : SLOT_W'(uops);
    end

    // Slot and grouping checks, independent of the handshake inputs.
    always_comb begin
        slots_fit  = (req <= avail_in);
        group_ok   = !bgn || (avail_in == W_S);
        considered = go_in && !blocked && slots_fit && group_ok;
    end

    // Readiness and acceptance including the three handshake inputs.
    always_comb begin
        ready  = considered && rob_ok && regs_ok && nxt_rdy;
        accept = valid && ready;
    end

    // Slot budget handed to the next lane and this lane's contribution.
    always_comb begin
        if (accept) begin
            avail_out  = endg ? '0 : (avail_in - req);
            slots_used = req;
            excess     = wide ? (uops - W_U) : '0;
        end else begin
            avail_out  = avail_in;
            slots_used = '0;
            excess     = '0;
        end
    end

    // Shortage indications for a lane that would otherwise have been checked.
    always_comb begin
        short_rob  = valid && considered && !rob_ok;
        short_regs = valid && considered && !regs_ok;
    end

endmodule

// File: rtl/dsp_carry.sv
// Module: dsp_carry
// Holds the carry-over micro-op count of an over-wide instruction and
// derives the slots left at the start of each cycle.
// Assumes at most one over-wide instruction enters per cycle, and only when carry is zero.
module dsp_carry #(
    parameter int unsigned EFF_W  = 4,
    parameter int unsigned UOP_W  = 4,
    parameter int unsigned SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UOP_W-1:0]  excess_in,
    output logic [UOP_W-1:0]  carry_level,
    output logic [SLOT_W-1:0] avail_start,
    output logic [SLOT_W-1:0] drained,
    output logic              drain_valid,
    output logic              block
);
    localparam logic [UOP_W-1:0]  W_U = UOP_W'(EFF_W);
    localparam logic [SLOT_W-1:0] W_S = SLOT_W'(EFF_W);

    logic [UOP_W-1:0] carry_q;
    logic [UOP_W-1:0] carry_d;

    // Slots free at cycle start after draining carry-over.
    always_comb begin
        if (carry_q == '0) begin
            avail_start = W_S;
        end else if (carry_q >= W_U) begin
            avail_start = '0;
        end else begin
            avail_start = W_S - SLOT_W'(carry_q);
        end
        drained     = W_S - avail_start;
        drain_valid = (carry_q != '0);
        block       = (carry_q > W_U);
    end

    // Next carry level: drained part removed, new excess added.
    always_comb begin
        carry_d = carry_q - UOP_W'(drained) + excess_in;
    end

    // Carry register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= '0;
        end else begin
            carry_q <= carry_d;
        end
    end

    assign carry_level = carry_q;

endmodule

// File: rtl/dsp_stall.sv
// Module: dsp_stall
// Registers the per-cycle shortage indications into stall flags.
// Assumes the lane shortage vectors are already qualified by validity.
module dsp_stall #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] short_rob,
    input  logic [LANES-1:0] short_regs,
    output logic             stall_rob,
    output logic             stall_regs
);
    // Capture any shortage of this cycle for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_rob  <= 1'b0;
            stall_regs <= 1'b0;
        end else begin
            stall_rob  <= |short_rob;
            stall_regs <= |short_regs;
        end
    end

endmodule

// File: rtl/uop_dispatch_ctrl.sv
// Module: uop_dispatch_ctrl
// Top of the dispatch slot controller: chains the lane deciders in program
// order, drains carry-over, sums the dispatched micro-ops and registers stalls.
// Assumes lane 0 is the oldest instruction and descriptors are held until taken.
module uop_dispatch_ctrl #(
    parameter int unsigned DISPATCH_WIDTH = 4,
    parameter int unsigned ISSUE_WIDTH    = 4,
    parameter int unsigned LANES          = 4,
    parameter int unsigned UOP_W          = 4,
    localparam int unsigned EFF_W  = dsp_pkg::eff_width(DISPATCH_WIDTH, ISSUE_WIDTH),
    localparam int unsigned SLOT_W = $clog2(EFF_W + 1),
    localparam int unsigned SUM_W  = $clog2(LANES * EFF_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       in_valid,
    input  logic [LANES*UOP_W-1:0] in_uops,
    input  logic [LANES-1:0]       in_bgn,
    input  logic [LANES-1:0]       in_end,
    input  logic [LANES-1:0]       rob_ok,
    input  logic [LANES-1:0]       regs_ok,
    input  logic [LANES-1:0]       nxt_rdy,
    output logic [LANES-1:0]       lane_rdy,
    output logic                   disp_valid,
    output logic [SUM_W-1:0]       disp_uops,
    output logic                   carry_valid,
    output logic [SLOT_W-1:0]      carry_uops,
    output logic                   stall_rob,
    output logic                   stall_regs
);
    logic [SLOT_W-1:0] avail_chain [LANES+1];
    logic              go_chain    [LANES+1];
    logic [SLOT_W-1:0] used_l      [LANES];
    logic [UOP_W-1:0]  excess_l    [LANES];
    logic [LANES-1:0]  accept_l;
    logic [LANES-1:0]  short_rob_l;
    logic [LANES-1:0]  short_regs_l;
    logic [UOP_W-1:0]  excess_sum;
    logic [UOP_W-1:0]  carry_level;
    logic [SLOT_W-1:0] slots_start;
    logic              carry_block;

    dsp_carry #(
        .EFF_W (EFF_W),
        .UOP_W (UOP_W),
        .SLOT_W(SLOT_W)
    ) u_carry (
        .clk        (clk),
        .rst_n      (rst_n),
        .excess_in  (excess_sum),
        .carry_level(carry_level),
        .avail_start(slots_start),
        .drained    (carry_uops),
        .drain_valid(carry_valid),
        .block      (carry_block)
    );

    assign avail_chain[0] = slots_start;
    assign go_chain[0]    = 1'b1;

    // One decider per lane, each fed the budget left by the older lanes.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dsp_lane #(
            .EFF_W (EFF_W),
            .UOP_W (UOP_W),
            .SLOT_W(SLOT_W)
        ) u_lane (
            .go_in     (go_chain[i]),
            .blocked   (carry_block),
            .avail_in  (avail_chain[i]),
            .valid     (in_valid[i]),
            .uops      (in_uops[i*UOP_W +: UOP_W]),
            .bgn       (in_bgn[i]),
            .endg      (in_end[i]),
            .rob_ok    (rob_ok[i]),
            .regs_ok   (regs_ok[i]),
            .nxt_rdy   (nxt_rdy[i]),
            .ready     (lane_rdy[i]),
            .accept    (accept_l[i]),
            .avail_out (avail_chain[i+1]),
            .slots_used(used_l[i]),
            .excess    (excess_l[i]),
            .short_rob (short_rob_l[i]),
            .short_regs(short_regs_l[i])
        );
        assign go_chain[i+1] = accept_l[i];
    end

    // Dispatch report and new carry-over summed across the lanes.
    always_comb begin
        disp_uops  = '0;
        excess_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            disp_uops  = disp_uops + SUM_W'(used_l[i]);
            excess_sum = excess_sum + excess_l[i];
        end
        disp_valid = |accept_l;
    end

    dsp_stall #(
        .LANES(LANES)
    ) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_rob (short_rob_l),
        .short_regs(short_regs_l),
        .stall_rob (stall_rob),
        .stall_regs(stall_regs)
    );

endmodule

// File: rtl/uop_dispatch_ctrl_chk.sv
// Module: uop_dispatch_ctrl_chk
// Property checker attached to the dispatch slot controller.
module uop_dispatch_ctrl_chk #(
    parameter int unsigned EFF_W  = 4,
    parameter int unsigned LANES  = 4,
    parameter int unsigned UOP_W  = 4,
    parameter int unsigned SLOT_W = 3,
    parameter int unsigned SUM_W  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       in_valid,
    input logic [LANES*UOP_W-1:0] in_uops,
    input logic [LANES-1:0]       lane_rdy,
    input logic [LANES-1:0]       rob_ok,
    input logic [SUM_W-1:0]       disp_uops,
    input logic                   carry_valid,
    input logic [SLOT_W-1:0]      carry_uops,
    input logic                   stall_rob,
    input logic [UOP_W-1:0]       carry_level,
    input logic [SLOT_W-1:0]      slots_start
);
    logic [LANES-1:0] acc;
    logic             wide_acc;

    // Accepted lanes and whether one of them was over-wide.
    always_comb begin
        acc      = in_valid & lane_rdy;
        wide_acc = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (acc[i] && (in_uops[i*UOP_W +: UOP_W] > UOP_W'(EFF_W))) wide_acc = 1'b1;
        end
    end

    // R3: never more micro-ops sent than slots free at cycle start.
    assert_slot_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(disp_uops) <= SUM_W'(slots_start));

    // R4: an accepted over-wide lane leaves carry-over for the next cycle.
    assert_wide_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wide_acc |=> carry_valid);

    // R5: a carry drain is non-empty and never exceeds the width.
    assert_carry_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_valid |-> (carry_uops != '0) && (carry_uops <= SLOT_W'(EFF_W)));

    // R6: carry beyond one cycle's drain blocks every lane.
    assert_carry_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_level > UOP_W'(EFF_W)) |-> (lane_rdy == '0));

    // R10: accepted lanes form a prefix from lane 0.
    assert_prefix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc + LANES'(1)) & acc) == '0);

    // R11: a retire stall needs a valid lane short of retire space one cycle earlier.
    assert_stall_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall_rob |-> $past(|(in_valid & ~rob_ok)));

endmodule

bind uop_dispatch_ctrl uop_dispatch_ctrl_chk #(
    .EFF_W (EFF_W),
    .LANES (LANES),
    .UOP_W (UOP_W),
    .SLOT_W(SLOT_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_uops    (in_uops),
    .lane_rdy   (lane_rdy),
    .rob_ok     (rob_ok),
    .disp_uops  (disp_uops),
    .carry_valid(carry_valid),
    .carry_uops (carry_uops),
    .stall_rob  (stall_rob),
    .carry_level(carry_level),
    .slots_start(slots_start)
);

// File: tb/sim_uop_dispatch_ctrl.sv
module sim_uop_dispatch_ctrl;
    localparam int PER = 10;
    localparam int L   = 4;
    localparam int UW  = 4;
    localparam int W   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [L-1:0]    in_valid = '0;
    logic [L*UW-1:0] in_uops = '0;
    logic [L-1:0]    in_bgn = '0, in_end = '0;
    logic [L-1:0]    rob_ok = '1, regs_ok = '1, nxt_rdy = '1;
    logic [L-1:0]    lane_rdy;
    logic            disp_valid;
    logic [4:0]      disp_uops;
    logic            carry_valid;
    logic [2:0]      carry_uops;
    logic            stall_rob, stall_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [L-1:0] rdy;
        logic         dv;
        logic [4:0]   du;
        logic         cv;
        logic [2:0]   cu;
        logic         sr;
        logic         sg;
        string        tag;
    } exp_t;

    exp_t q[$];

    int  m_carry = 0;
    bit  m_sr = 0, m_sg = 0;

    always #(PER/2) clk = ~clk;

    uop_dispatch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .in_bgn(in_bgn), .in_end(in_end), .rob_ok(rob_ok), .regs_ok(regs_ok),
        .nxt_rdy(nxt_rdy), .lane_rdy(lane_rdy), .disp_valid(disp_valid),
        .disp_uops(disp_uops), .carry_valid(carry_valid), .carry_uops(carry_uops),
        .stall_rob(stall_rob), .stall_regs(stall_regs)
    );

    // Driver: applies one cycle of stimulus and pushes the expected outputs.
    task automatic drive(input logic [L-1:0] v, input logic [L*UW-1:0] u,
                         input logic [L-1:0] bg, input logic [L-1:0] en,
                         input logic [L-1:0] rb, input logic [L-1:0] rg,
                         input logic [L-1:0] nx, input string tag);
        exp_t e;
        int av, used, exc, disp;
        bit go, blk, any, nsr, nsg;
        @(negedge clk);
        in_valid = v; in_uops = u; in_bgn = bg; in_end = en;
        rob_ok = rb; regs_ok = rg; nxt_rdy = nx;
        av   = (m_carry == 0) ? W : ((m_carry >= W) ? 0 : W - m_carry);
        used = W - av;
        blk  = (m_carry > W);
        go = 1; exc = 0; disp = 0; any = 0; nsr = 0; nsg = 0;
        e.rdy = '0;
        for (int i = 0; i < L; i++) begin
            int n, req;
            bit cons;
            n    = int'(u[i*UW +: UW]);
            req  = (n > W) ? W : n;
            cons = go && !blk && (req <= av) && (!bg[i] || av == W);
            e.rdy[i] = cons && rb[i] && rg[i] && nx[i];
            if (v[i] && cons && !rb[i]) nsr = 1;
            if (v[i] && cons && !rg[i]) nsg = 1;
            if (v[i] && e.rdy[i]) begin
                any = 1; disp += req;
                if (n > W) exc += n - W;
                av = en[i] ? 0 : av - req;
                go = 1;
            end else begin
                go = 0;
            end
        end
        e.dv = any; e.du = 5'(disp);
        e.cv = (m_carry != 0); e.cu = 3'((m_carry != 0) ? used : 0);
        e.sr = m_sr; e.sg = m_sg; e.tag = tag;
        q.push_back(e);
        m_carry = m_carry - ((m_carry != 0) ? used : 0) + exc;
        m_sr = nsr; m_sg = nsg;
    endtask

    // Monitor: pops the expected item for each cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #(PER/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({lane_rdy, disp_valid, disp_uops, carry_valid, carry_uops, stall_rob, stall_regs} !==
                    {e.rdy, e.dv, e.du, e.cv, e.cu, e.sr, e.sg}) begin
                    errors++;
                    $display("FAIL %s rdy=%b dv=%b du=%0d cv=%b cu=%0d sr=%b sg=%b exp rdy=%b dv=%b du=%0d cv=%b cu=%0d sr=%b sg=%b",
                             e.tag, lane_rdy, disp_valid, disp_uops, carry_valid, carry_uops, stall_rob, stall_regs,
                             e.rdy, e.dv, e.du, e.cv, e.cu, e.sr, e.sg);
                end
            end
        end
    end

    function automatic logic [L*UW-1:0] pk(input int a, input int b, input int c, input int d);
        return {UW'(d), UW'(c), UW'(b), UW'(a)};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(PER*200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle cycle straight after reset; no carry, no stall, full width
        drive('0, '0, '0, '0, '1, '1, '1, "R1");
        // R2, R12: four single micro-op lanes all go
        drive(4'b1111, pk(1,1,1,1), '0, '0, '1, '1, '1, "R2");
        // R3: 2+2 fill the width, the third lane is refused
        drive(4'b0111, pk(2,2,1,0), '0, '0, '1, '1, '1, "R3");
        // R4: over-wide lane behind another lane cannot take all slots
        drive(4'b0011, pk(2,6,0,0), '0, '0, '1, '1, '1, "R4");
        // R4: over-wide lane first, leaves carry 2
        drive(4'b0001, pk(6,0,0,0), '0, '0, '1, '1, '1, "R4");
        // R5: carry 2 drains, two slots left for new lanes
        drive(4'b0111, pk(1,1,1,0), '0, '0, '1, '1, '1, "R5");
        // R4: eleven micro-ops leave carry 7
        drive(4'b0001, pk(11,0,0,0), '0, '0, '1, '1, '1, "R4");
        // R6: carry 7 drains 4, nothing else may go
        drive(4'b1111, pk(0,0,0,0), '0, '0, '1, '1, '1, "R6");
        // R5: carry 3 drains, one slot remains
        drive(4'b0011, pk(1,1,0,0), '0, '0, '1, '1, '1, "R5");
        // R7: begin-group behind a used slot is refused
        drive(4'b0011, pk(1,1,0,0), 4'b0010, '0, '1, '1, '1, "R7");
        // R7: begin-group on a fresh cycle is taken
        drive(4'b0011, pk(1,1,0,0), 4'b0001, '0, '1, '1, '1, "R7");
        // R8: end-group closes the cycle for later lanes
        drive(4'b0011, pk(1,1,0,0), '0, 4'b0001, '1, '1, '1, "R8");
        // R9, R11: retire shortage on lane 0
        drive(4'b0011, pk(1,1,0,0), '0, '0, 4'b1110, '1, '1, "R9");
        // R9, R11: register shortage on lane 1, retire stall now visible
        drive(4'b0011, pk(1,1,0,0), '0, '0, '1, 4'b1101, '1, "R11");
        // R9: next stage not ready on lane 0, register stall visible
        drive(4'b0011, pk(1,1,0,0), '0, '0, '1, '1, 4'b1110, "R9");
        // R10: a hole at lane 1 stops lane 2
        drive(4'b0101, pk(1,1,1,0), '0, '0, '1, '1, '1, "R10");
        // R2: fresh cycle after idle has full width
        drive('0, '0, '0, '0, '1, '1, '1, "R2");
        drive(4'b0001, pk(4,0,0,0), '0, '0, '1, '1, '1, "R12");
        // Mixed traffic across all requirements
        for (int k = 0; k < 400; k++) begin
            logic [L*UW-1:0] u;
            logic [L-1:0] v, bg, en, rb, rg, nx;
            for (int i = 0; i < L; i++) begin
                int r = int'($urandom_range(0, 9));
                u[i*UW +: UW] = UW'((r < 7) ? $urandom_range(0, 3) : $urandom_range(4, 12));
                v[i]  = ($urandom_range(0, 4) != 0);
                bg[i] = ($urandom_range(0, 7) == 0);
                en[i] = ($urandom_range(0, 7) == 0);
                rb[i] = ($urandom_range(0, 6) != 0);
                rg[i] = ($urandom_range(0, 6) != 0);
                nx[i] = ($urandom_range(0, 6) != 0);
            end
            drive(v, u, bg, en, rb, rg, nx, "R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 mix");
        end
        @(negedge clk);
        #(PER/2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule